// File: doc/BRIEF.md
# Grouped Interrupt Expander

This block gathers a large set of peripheral interrupt request lines, twelve groups of eight by default, and folds each group onto one CPU interrupt line. Every source has its own flag and enable bit. Every group has an acknowledge bit, and every CPU line has a line flag and a line enable. A single global mask sits over all of them. When an interrupt can be taken, the block picks one line and one source, computes the entry number in the vector table in hardware, and offers that number to the CPU. Software never has to scan flags to find out who asked.

The offer is a valid/ready stream of one word. `take_valid` rises when a line is chosen. From then on, `take_vec` and `take_line` stay frozen until the CPU asserts `take_ready` in the same cycle, however the flags change meanwhile. The block never withdraws an offer. The CPU may hold `take_ready` low for as long as it needs. Acceptance does the bookkeeping in hardware: it clears the flags, sets the group acknowledge, sets the mask and saves the line enables. It also starts an eight-step context-save strobe that the CPU's save logic follows.

A small register port gives software access to the control bits, line enables, line flags, acknowledges, saved enables, per-group enables and per-group flags. Reads are combinational and writes take effect at the clock edge.

Top module: `grp_irq_expander`

## Requirements
- R1: A rising edge on source s of group g sets that source's flag. A level held high does not set it again after it has been cleared. Writing 1 to bit s at address 32+g clears the flag, and the flag byte reads back at that address.
- R2: A group requests when any of its flags is set together with its enable bit (address 16+g). The line flag g is set when the group requests and its acknowledge bit is clear. `cpu_line` shows line flags ANDed with the line enables (address 1).
- R3: An offer is made only when the global mask is clear and no context save is running. Among the candidate lines, the lowest group index wins. Within the group, the lowest enabled pending source wins.
- R4: In table mode (control bit 0 = 1), `take_vec` = 32 + 8*g + s. In boot mode (bit 0 = 0), `take_vec` = g + 1.
- R5: While `take_valid` is high and `take_ready` is low, `take_valid`, `take_vec` and `take_line` hold their values.
- R6: On acceptance, line flag g is cleared. In table mode, the chosen source flag is also cleared and acknowledge bit g is set. In boot mode, the source flags and acknowledges are left unchanged.
- R7: While acknowledge bit g (address 3) is set, line flag g cannot be set. Writing 1 to that bit releases the group.
- R8: Acceptance sets the global mask (control bit 1), copies the line enables to the saved-enable register (address 4) and clears line enable g. Writing 1 to bit 0 of address 5 restores the line enables from the saved copy and clears the mask.
- R9: In the cycle after acceptance, `save_valid` rises with `save_step` = 0. It stays high for 8 consecutive cycles while `save_step` counts 0 to 7 in fixed order.
- R10: After reset, the global mask is set, table mode is off, and all enables, flags, acknowledges and offers are clear.
- R11: If a rising edge and a clear write hit the same source flag in the same cycle, the flag ends up set.
- R12: Register map: 0 = control {mask, table}, 1 = line enables, 2 = line flags (write 1 clears), 3 = acknowledges (write 1 clears), 4 = saved enables, 5 = return, 16+g = group enable, 32+g = group flags. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl | input | 96 | Peripheral request levels, bit 8*g+s |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Register read data (combinational) |
| cpu_line | output | 12 | Line flags ANDed with line enables |
| take_valid | output | 1 | Vector offer valid |
| take_ready | input | 1 | CPU accepts the offer |
| take_vec | output | 8 | Vector table index |
| take_line | output | 4 | Offered group index |
| save_valid | output | 1 | Context-save strobe |
| save_step | output | 3 | Context-save step number |

## Verification
The embedded assertions check on every cycle that a held offer stays frozen and that offers only start with the mask clear. They also check that acceptance masks further interrupts, clears the taken line flag and starts the save sequence at step 0. Further cycle-by-cycle checks cover the stepwise advance of the save strobe and the rule that an acknowledged group's line flag stays clear. Several behaviours need the bench's scenarios and its reference model: choosing among simultaneous requests, the exact vector numbers in both modes, level inputs not re-flagging, and the edge-beats-clear collision. The same applies to the restore on return and the register readback.

// File: rtl/gie_pkg.sv
package gie_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 6'd0;
  localparam logic [ADDR_W-1:0] ADR_LEN   = 6'd1;
  localparam logic [ADDR_W-1:0] ADR_LFLG  = 6'd2;
  localparam logic [ADDR_W-1:0] ADR_ACK   = 6'd3;
  localparam logic [ADDR_W-1:0] ADR_SAVED = 6'd4;
  localparam logic [ADDR_W-1:0] ADR_RET   = 6'd5;
  localparam int                ADR_GEN_BASE = 16;
  localparam int                ADR_GFL_BASE = 32;

  // context-save order; the sequence is behaviour, so the encoding is fixed
  typedef enum logic [2:0] {
    SV_TMP_STAT0  = 3'd0,
    SV_ACC_PAIR   = 3'd1,
    SV_PROD_PAIR  = 3'd2,
    SV_PTR_PAIR   = 3'd3,
    SV_PAGE_STAT1 = 3'd4,
    SV_DBG_ENA    = 3'd5,
    SV_PC_HI      = 3'd6,
    SV_PC_LO      = 3'd7
  } save_step_e;

  localparam int SAVE_STEPS = 8;
endpackage

// File: rtl/gie_lowest.sv
module gie_lowest #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign found = |req;
endmodule

// File: rtl/gie_group.sv
module gie_group #(
  parameter int NSRC = 8,
  parameter int SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_lvl,
  input  logic            en_wr,
  input  logic            flag_w1c,
  input  logic [NSRC-1:0] wdata,
  input  logic            take_clr,
  input  logic [SW-1:0]   take_src,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] flag_q,
  output logic            req,
  output logic [SW-1:0]   low_src
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] take_mask;
  logic            unused_found;

  assign rise      = src_lvl & ~prev_q;
  assign take_mask = take_clr ? (NSRC'(1) << take_src) : '0;
  assign clr       = (flag_w1c ? wdata : '0) | take_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      prev_q <= src_lvl;
      flag_q <= (flag_q & ~clr) | rise;  // a new edge beats a clear
      if (en_wr) en_q <= wdata;
    end
  end

  gie_lowest #(.N(NSRC), .IW(SW)) u_pick (
    .req  (flag_q & en_q),
    .found(unused_found),
    .idx  (low_src)
  );
  assign req = unused_found;

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_lvl[0] && !prev_q[0]) |=> flag_q[0]);  // R11
endmodule

// File: rtl/gie_save_seq.sv
module gie_save_seq #(
  parameter int NSTEP = 8,
  parameter int STW   = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy_q,
  output logic [STW-1:0] step_q
);
  localparam logic [STW-1:0] LAST = STW'(NSTEP - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      step_q <= '0;
    end else if (busy_q) begin
      if (step_q == LAST) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && step_q != LAST && !start) |=> (busy_q && step_q == $past(step_q) + 1'b1));  // R9
endmodule

// File: rtl/grp_irq_expander.sv
module grp_irq_expander
  import gie_pkg::*;
#(
  parameter int NGRP     = 12,
  parameter int NSRC     = 8,
  parameter int VEC_BASE = 32,
  parameter int VW       = 8,
  parameter int RW       = (NGRP > NSRC) ? NGRP : NSRC,
  parameter int GW       = (NGRP > 1) ? $clog2(NGRP) : 1,
  parameter int SW       = (NSRC > 1) ? $clog2(NSRC) : 1,
  parameter int STW      = $clog2(SAVE_STEPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NGRP*NSRC-1:0] irq_lvl,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [RW-1:0]        reg_wdata,
  output logic [RW-1:0]        reg_rdata,
  output logic [NGRP-1:0]      cpu_line,
  output logic                 take_valid,
  input  logic                 take_ready,
  output logic [VW-1:0]        take_vec,
  output logic [GW-1:0]        take_line,
  output logic                 save_valid,
  output logic [STW-1:0]       save_step
);
  logic [NSRC-1:0] grp_en   [NGRP];
  logic [NSRC-1:0] grp_flag [NGRP];
  logic [SW-1:0]   grp_low  [NGRP];
  logic [NGRP-1:0] grp_req;

  logic [NGRP-1:0] lflag_q, len_q, ack_q, saved_q;
  logic            gmask_q, tbl_q;
  logic            offer_v_q, offer_t_q;
  logic [GW-1:0]   offer_g_q;
  logic [SW-1:0]   offer_s_q;

  logic            acc;
  logic            wr_ctrl, wr_len, wr_lflg, wr_ack, wr_ret;
  logic [NGRP-1:0] cand;
  logic            cand_found;
  logic [GW-1:0]   cand_g;

  assign acc     = offer_v_q && take_ready;
  assign wr_ctrl = reg_wr && reg_addr == ADR_CTRL;
  assign wr_len  = reg_wr && reg_addr == ADR_LEN;
  assign wr_lflg = reg_wr && reg_addr == ADR_LFLG;
  assign wr_ack  = reg_wr && reg_addr == ADR_ACK;
  assign wr_ret  = reg_wr && reg_addr == ADR_RET && reg_wdata[0];

  // per-group source flags, enables and in-group selection
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    gie_group #(.NSRC(NSRC), .SW(SW)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_lvl (irq_lvl[g*NSRC +: NSRC]),
      .en_wr   (reg_wr && reg_addr == ADDR_W'(ADR_GEN_BASE + g)),
      .flag_w1c(reg_wr && reg_addr == ADDR_W'(ADR_GFL_BASE + g)),
      .wdata   (reg_wdata[NSRC-1:0]),
      .take_clr(acc && offer_t_q && offer_g_q == GW'(g)),
      .take_src(offer_s_q),
      .en_q    (grp_en[g]),
      .flag_q  (grp_flag[g]),
      .req     (grp_req[g]),
      .low_src (grp_low[g])
    );

    // line flag: clear beats set; acknowledge: set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lflag_q[g] <= 1'b0;
        ack_q[g]   <= 1'b0;
      end else begin
        if ((wr_lflg && reg_wdata[g]) || (acc && offer_g_q == GW'(g)))
          lflag_q[g] <= 1'b0;
        else if (grp_req[g] && !ack_q[g])
          lflag_q[g] <= 1'b1;
        if (acc && offer_t_q && offer_g_q == GW'(g))
          ack_q[g] <= 1'b1;
        else if (wr_ack && reg_wdata[g])
          ack_q[g] <= 1'b0;
      end
    end

    AST_ACK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_q[g] && !lflag_q[g]) |=> !lflag_q[g]);  // R7
  end

  // line selection across groups
  assign cand = lflag_q & len_q & grp_req;
  gie_lowest #(.N(NGRP), .IW(GW)) u_line_pick (
    .req  (cand),
    .found(cand_found),
    .idx  (cand_g)
  );

  // mask, enables, saved enables, table mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask_q <= 1'b1;
      tbl_q   <= 1'b0;
      len_q   <= '0;
      saved_q <= '0;
    end else begin
      if (wr_ctrl) begin
        tbl_q   <= reg_wdata[0];
        gmask_q <= reg_wdata[1];
      end
      if (wr_ret) begin
        len_q   <= saved_q;
        gmask_q <= 1'b0;
      end
      if (wr_len) len_q <= reg_wdata[NGRP-1:0];
      if (acc) begin
        gmask_q           <= 1'b1;
        saved_q           <= len_q;
        len_q[offer_g_q]  <= 1'b0;
      end
    end
  end

  // offer register: frozen until accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offer_v_q <= 1'b0;
      offer_t_q <= 1'b0;
      offer_g_q <= '0;
      offer_s_q <= '0;
    end else if (!offer_v_q || acc) begin
      offer_v_q <= !acc && cand_found && !gmask_q && !save_valid;
      offer_t_q <= tbl_q;
      offer_g_q <= cand_g;
      offer_s_q <= grp_low[cand_g];
    end
  end

  gie_save_seq #(.NSTEP(SAVE_STEPS), .STW(STW)) u_save (
    .clk   (clk),
    .rst_n (rst_n),
    .start (acc),
    .busy_q(save_valid),
    .step_q(save_step)
  );

  assign take_valid = offer_v_q;
  assign take_line  = offer_g_q;
  assign take_vec   = offer_t_q ? VW'(VEC_BASE + NSRC * int'(offer_g_q) + int'(offer_s_q))
                                : VW'(int'(offer_g_q) + 1);
  assign cpu_line   = lflag_q & len_q;

  // register read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CTRL:  reg_rdata = RW'({gmask_q, tbl_q});
      ADR_LEN:   reg_rdata = RW'(len_q);
      ADR_LFLG:  reg_rdata = RW'(lflag_q);
      ADR_ACK:   reg_rdata = RW'(ack_q);
      ADR_SAVED: reg_rdata = RW'(saved_q);
      default:   reg_rdata = '0;
    endcase
    for (int g = 0; g < NGRP; g++) begin
      if (reg_addr == ADDR_W'(ADR_GEN_BASE + g)) reg_rdata = RW'(grp_en[g]);
      if (reg_addr == ADDR_W'(ADR_GFL_BASE + g)) reg_rdata = RW'(grp_flag[g]);
    end
  end

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && !take_ready) |=> (take_valid && $stable(take_vec) && $stable(take_line)));  // R5
  AST_OFFER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_valid) |-> $past(!gmask_q));  // R3
  AST_ACCEPT_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_ready) |=> gmask_q);  // R8
  AST_ACCEPT_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_ready) |=> !lflag_q[$past(take_line)]);  // R6
  AST_SAVE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_ready) |=> (save_valid && save_step == '0));  // R9
endmodule

// File: tb/grp_irq_expander_test.sv
module grp_irq_expander_test;
  localparam int CLK_NS = 10;
  localparam int NG = 12;
  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] irq = '0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic [11:0] reg_rdata;
  logic [11:0] cpu_line;
  logic        take_valid;
  logic        take_ready = 1'b0;
  logic [7:0]  take_vec;
  logic [3:0]  take_line;
  logic        save_valid;
  logic [2:0]  save_step;

  grp_irq_expander uut (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_line(cpu_line),
    .take_valid(take_valid), .take_ready(take_ready), .take_vec(take_vec),
    .take_line(take_line), .save_valid(save_valid), .save_step(save_step)
  );

  always #(CLK_NS/2) clk = ~clk;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [95:0] m_prev, m_flag, m_en;
  logic [11:0] m_ack, m_lf, m_len, m_saved;
  logic        m_mask, m_tbl, m_ov, m_ot, m_busy;
  int          m_og, m_os, m_step;

  function automatic bit m_req(int g);
    return |(m_flag[g*NS +: NS] & m_en[g*NS +: NS]);
  endfunction

  function automatic int m_low(int g);
    for (int s = 0; s < NS; s++) if (m_flag[g*NS+s] && m_en[g*NS+s]) return s;
    return 0;
  endfunction

  function automatic logic [11:0] m_read(logic [5:0] a);
    if (a == 0) return {10'd0, m_mask, m_tbl};
    if (a == 1) return m_len;
    if (a == 2) return m_lf;
    if (a == 3) return m_ack;
    if (a == 4) return m_saved;
    if (a >= 16 && a < 16 + NG) return {4'd0, m_en[(a-16)*NS +: NS]};
    if (a >= 32 && a < 32 + NG) return {4'd0, m_flag[(a-32)*NS +: NS]};
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = '0; m_flag = '0; m_en = '0; m_ack = '0; m_lf = '0; m_len = '0;
      m_saved = '0; m_mask = 1; m_tbl = 0; m_ov = 0; m_ot = 0; m_busy = 0;
      m_og = 0; m_os = 0; m_step = 0;
    end else begin
      automatic bit acc = m_ov && take_ready;
      automatic logic [95:0] n_flag = m_flag, n_en = m_en;
      automatic logic [11:0] n_ack = m_ack, n_lf = m_lf, n_len = m_len, n_saved = m_saved;
      automatic logic n_mask = m_mask, n_tbl = m_tbl, n_ov = m_ov, n_ot = m_ot, n_busy = m_busy;
      automatic int n_og = m_og, n_os = m_os, n_step = m_step;
      for (int i = 0; i < NG*NS; i++) begin
        if (reg_wr && reg_addr == 32 + i/NS && reg_wdata[i%NS]) n_flag[i] = 0;
        if (acc && m_ot && m_og == i/NS && m_os == i%NS) n_flag[i] = 0;
        if (irq[i] && !m_prev[i]) n_flag[i] = 1;
      end
      for (int g = 0; g < NG; g++) begin
        if (reg_wr && reg_addr == 16 + g) n_en[g*NS +: NS] = reg_wdata[7:0];
        if (m_req(g) && !m_ack[g]) n_lf[g] = 1;
        if (reg_wr && reg_addr == 2 && reg_wdata[g]) n_lf[g] = 0;
        if (acc && m_og == g) n_lf[g] = 0;
        if (reg_wr && reg_addr == 3 && reg_wdata[g]) n_ack[g] = 0;
        if (acc && m_ot && m_og == g) n_ack[g] = 1;
      end
      if (reg_wr && reg_addr == 0) begin n_tbl = reg_wdata[0]; n_mask = reg_wdata[1]; end
      if (reg_wr && reg_addr == 5 && reg_wdata[0]) begin n_len = m_saved; n_mask = 0; end
      if (reg_wr && reg_addr == 1) n_len = reg_wdata;
      if (acc) begin n_mask = 1; n_saved = m_len; n_len[m_og] = 0; end
      if (!m_ov || acc) begin
        n_ov = 0;
        if (!acc && !m_mask && !m_busy) begin
          for (int g = NG - 1; g >= 0; g--) begin
            if (m_lf[g] && m_len[g] && m_req(g)) begin
              n_ov = 1; n_og = g; n_os = m_low(g); n_ot = m_tbl;
            end
          end
        end
      end
      if (acc) begin n_busy = 1; n_step = 0; end
      else if (m_busy) begin
        if (m_step == 7) begin n_busy = 0; n_step = 0; end
        else n_step = m_step + 1;
      end
      m_prev = irq; m_flag = n_flag; m_en = n_en; m_ack = n_ack; m_lf = n_lf;
      m_len = n_len; m_saved = n_saved; m_mask = n_mask; m_tbl = n_tbl;
      m_ov = n_ov; m_ot = n_ot; m_og = n_og; m_os = n_os; m_busy = n_busy; m_step = n_step;
    end
  end

  // compare with the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 take_valid vs model", take_valid, m_ov);
      if (m_ov) begin
        chk("R4 take_vec vs model", take_vec, m_ot ? 32 + 8*m_og + m_os : m_og + 1);
        chk("R3 take_line vs model", take_line, m_og);
      end
      chk("R2 cpu_line vs model", cpu_line, m_lf & m_len);
      chk("R9 save_valid vs model", save_valid, m_busy);
      if (m_busy) chk("R9 save_step vs model", save_step, m_step);
      chk("R12 reg_rdata vs model", reg_rdata, m_read(reg_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [5:0] a, logic [11:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, logic [11:0] exp, string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic accept_and_return;
    take_ready = 1; tick(1); take_ready = 0;
    tick(10);
    wr(6'd5, 12'h001);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    rd(6'd0, 12'h002, "R10 control after reset");
    rd(6'd1, 12'h000, "R10 line enables after reset");
    chk("R10 no offer after reset", take_valid, 0);

    wr(6'd0, 12'h001);
    wr(6'd1, 12'hFFF);
    for (int g = 0; g < NG; g++) wr(6'(16 + g), 12'h0FF);

    // group 3 source 5, offer held with ready low
    irq[29] = 1; tick(4);
    chk("R4 table vector g3 s5", take_vec, 61);
    rd(6'd35, 12'h020, "R1 edge sets flag");
    irq[10] = 1; tick(4);
    chk("R5 offer frozen under back-pressure", take_vec, 61);
    take_ready = 1; tick(1); take_ready = 0;
    chk("R9 save starts at step 0", {save_valid, save_step}, 4'b1000);
    rd(6'd35, 12'h000, "R6 source flag cleared");
    rd(6'd3, 12'h008, "R6 group ack set");
    rd(6'd0, 12'h003, "R8 mask set on accept");
    rd(6'd4, 12'hFFF, "R8 enables saved");
    rd(6'd1, 12'hFF7, "R8 taken line enable cleared");
    tick(10);
    chk("R8 no offer while masked", take_valid, 0);
    wr(6'd5, 12'h001);
    tick(4);
    chk("R3 next line offered after return", take_vec, 42);
    accept_and_return();

    // acknowledged group stays blocked
    irq[29] = 0; tick(1); irq[25] = 1; tick(4);
    chk("R7 acked group not on cpu line", cpu_line[3], 0);
    chk("R7 no offer from acked group", take_valid, 0);
    rd(6'd35, 12'h002, "R1 held level did not re-flag");
    wr(6'd3, 12'h008); tick(4);
    chk("R7 group released by ack write", take_vec, 57);
    accept_and_return();
    wr(6'd3, 12'hFFF); tick(2);

    // simultaneous requests: priority
    wr(6'd0, 12'h003);
    irq[62] = 1; irq[60] = 1; irq[23] = 1; tick(4);
    wr(6'd0, 12'h001); tick(3);
    chk("R3 lowest group wins", take_vec, 55);
    accept_and_return(); tick(4);
    chk("R3 lowest source in group wins", take_vec, 92);
    accept_and_return(); tick(4);
    chk("R7 second source waits for ack", take_valid, 0);
    wr(6'd3, 12'hFFF); tick(4);
    chk("R3 remaining source offered", take_vec, 94);
    accept_and_return();
    wr(6'd3, 12'hFFF);

    // boot mode
    wr(6'd0, 12'h000);
    irq[0] = 1; tick(4);
    chk("R4 boot vector", take_vec, 1);
    take_ready = 1; tick(1); take_ready = 0;
    rd(6'd32, 12'h001, "R6 boot mode keeps source flag");
    rd(6'd3, 12'h000, "R6 boot mode leaves ack");
    tick(10);
    wr(6'd32, 12'h001);
    wr(6'd2, 12'h001);
    wr(6'd5, 12'h001); tick(4);
    chk("R6 nothing pending after clears", take_valid, 0);

    // edge and clear in the same cycle
    wr(6'd0, 12'h002);
    reg_wr = 1; reg_addr = 6'd37; reg_wdata = 12'h001; irq[40] = 1;
    tick(1); reg_wr = 0;
    rd(6'd37, 12'h001, "R11 edge beats clear");

    // group enable gates the line
    wr(6'd25, 12'h000);
    irq[72] = 1; tick(4);
    rd(6'd41, 12'h001, "R1 flag set while group disabled");
    chk("R2 disabled group not on cpu line", cpu_line[9], 0);
    chk("R2 enabled pending group on cpu line", cpu_line[5], 1);
    rd(6'd1, 12'hFFF, "R12 line enables restored");
    rd(6'd7, 12'h000, "R12 unmapped address reads zero");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule